// File: doc/BRIEF.md
# GPIO Pad Bank Controller with Event Interrupts

This block is a memory-mapped controller for a single bank of up to 32 general-purpose pads. Each pad owns two 32-bit configuration words inside a pad region. The first word drives the output level and selects how the pad's input produces events. The second word is a general 32-bit configuration word kept for software. A pointer register at a fixed address reports where the pad region starts, so driver code can locate the pads without knowing the layout in advance.

Every pad input goes through a two-flop synchronizer and an optional inversion. It then reaches an event detector that works in level, rising-edge or both-edge mode. Each detected event sets a sticky status bit, and software acknowledges it by writing a one to that bit. A separate enable register chooses which status bits drive the single registered interrupt output. Register access uses a simple valid/write/address/data request. A read returns its data one cycle after the request.

Top module: `gpio_pad_ctrl`

## Requirements
- R1: After a synchronous reset, these are all zero: every configuration field, the status register, the enable register, `pad_out` and `irq`.
- R2: A read of address 0x00C returns the pad region byte offset (parameter `PAD_REGION_OFS`, default 0x400). Writes to that address have no effect.
- R3: Pad n's first config word is at `PAD_REGION_OFS + n*PAD_STRIDE` and its second word is 4 bytes above it. The second word stores all 32 bits. Any other offset inside a pad slot reads zero, and so does any address that maps to nothing.
- R4: Bit 0 of a pad's first word drives `pad_out[n]`. Bit 1 reads the synchronized input level before inversion, and writes to bit 1 are ignored.
- R5: In the first word, these fields can be read and written: bits 31:30 (reset-configuration), bits 26:25 (event mode) and bit 23 (invert). All bits not named in R4 or R5 read zero.
- R6: Event mode 00 is level mode. The status bit is set on every cycle that the inverted-or-not input is high, so it comes back after a clear while the input stays high.
- R7: Event mode 01 sets status only on a rising edge of the post-inversion input. A falling edge does nothing.
- R8: Event mode 11 sets status on both edges. Event mode 10 never sets status.
- R9: Bit 23 inverts the input before event detection. For example, in level mode a low input raises status.
- R10: Status lives at `STS_BASE` (default 0x100), with bit i for pad i. Writing a 1 clears that bit, and zero bits in the write leave it alone. If an event and a clear hit the same bit in the same cycle, the bit stays set.
- R11: Enable lives at `ENA_BASE` (default 0x120) and can be read and written. Status bits still set while their enable bit is clear.
- R12: `irq` is a registered output. It is high on the cycle after the AND of status and enable is non-zero, and low on the cycle after that AND is zero.
- R13: `rsp_valid` pulses with `rsp_rdata` exactly one cycle after an accepted read. Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| pad_in | input | NUM_PADS | Asynchronous pad input levels |
| pad_out | output | NUM_PADS | Pad output levels |
| irq | output | 1 | Aggregated interrupt |

## Verification
The detector is driven with a high level, a held high level, a rising step and a falling step. Each is applied under all four mode codes, with and without inversion. These cases tell level, rise-only, both-edge and disabled detection apart, and show whether inversion acts before detection. Acknowledge writes use all-zero, single-bit and all-ones data while an input is still active. This separates true write-one-to-clear from level re-assertion. Status is raised with the matching enable bit off, with a neighbouring enable bit on, and with the matching enable bit on. This shows that gating happens only at the interrupt output.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;

  // Event detection codes held in config word 0 bits 26:25
  typedef enum logic [1:0] {
    EVT_LEVEL = 2'b00,
    EVT_RISE  = 2'b01,
    EVT_NONE  = 2'b10,
    EVT_BOTH  = 2'b11
  } evt_mode_e;

  localparam int PTR_OFS   = 'h00C;
  localparam int TX_BIT    = 0;
  localparam int RX_BIT    = 1;
  localparam int INV_BIT   = 23;
  localparam int MODE_LSB  = 25;
  localparam int RCFG_LSB  = 30;
  localparam int DW1_OFS   = 4;

endpackage

// File: rtl/gpio_pad_evt.sv
module gpio_pad_evt
  import gpio_pad_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      pad_i,
  input  logic      inv_i,
  input  evt_mode_e mode_i,
  output logic      rx_sync_o,
  output logic      evt_o
);

  logic meta_q, sync_q, prev_q;
  logic rx_now;

  assign rx_now    = sync_q ^ inv_i;
  assign rx_sync_o = sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= pad_i;
      sync_q <= meta_q;
      prev_q <= rx_now;
    end
  end

  always_comb begin
    unique case (mode_i)
      EVT_LEVEL: evt_o = rx_now;
      EVT_RISE:  evt_o = rx_now & ~prev_q;
      EVT_BOTH:  evt_o = rx_now ^ prev_q;
      default:   evt_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/gpio_irq_agg.sv
module gpio_irq_agg #(
  parameter int NUM_PADS = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PADS-1:0] sts_i,
  input  logic [NUM_PADS-1:0] ena_i,
  output logic                irq_o
);

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(sts_i & ena_i);
  end

endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
  import gpio_pad_pkg::*;
#(
  parameter int ADDR_W         = 12,
  parameter int NUM_PADS       = 32,
  parameter int PAD_STRIDE     = 16,
  parameter int PAD_REGION_OFS = 'h400,
  parameter int STS_BASE       = 'h100,
  parameter int ENA_BASE       = 'h120
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [31:0]         req_wdata,
  output logic                rsp_valid,
  output logic [31:0]         rsp_rdata,
  input  logic [NUM_PADS-1:0] pad_in,
  output logic [NUM_PADS-1:0] pad_out,
  output logic                irq
);

  localparam int STRIDE_LG    = $clog2(PAD_STRIDE);
  localparam int IDX_W        = (NUM_PADS > 1) ? $clog2(NUM_PADS) : 1;
  localparam int REGION_BYTES = NUM_PADS * PAD_STRIDE;

  // ---------------- address decode ----------------
  logic [ADDR_W-1:0]    rel_addr;
  logic                 in_region, hit_dw0, hit_dw1;
  logic                 hit_ptr, hit_sts, hit_ena;
  logic [IDX_W-1:0]     pad_idx;
  logic [STRIDE_LG-1:0] slot_ofs;
  logic                 wr;

  assign wr        = req_valid & req_write;
  assign rel_addr  = req_addr - ADDR_W'(PAD_REGION_OFS);
  assign in_region = (32'(req_addr) >= 32'(PAD_REGION_OFS)) &&
                     (32'(rel_addr) < 32'(REGION_BYTES));
  assign pad_idx   = IDX_W'(rel_addr >> STRIDE_LG);
  assign slot_ofs  = rel_addr[STRIDE_LG-1:0];
  assign hit_dw0   = in_region && (slot_ofs == '0);
  assign hit_dw1   = in_region && (slot_ofs == STRIDE_LG'(DW1_OFS));
  assign hit_ptr   = (req_addr == ADDR_W'(PTR_OFS));
  assign hit_sts   = (req_addr == ADDR_W'(STS_BASE));
  assign hit_ena   = (req_addr == ADDR_W'(ENA_BASE));

  // ---------------- per-pad configuration ----------------
  logic [NUM_PADS-1:0] tx_q;
  logic [NUM_PADS-1:0] inv_q;
  evt_mode_e           mode_q [NUM_PADS];
  logic [1:0]          rcfg_q [NUM_PADS];
  logic [31:0]         dw1_q  [NUM_PADS];

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q  <= '0;
      inv_q <= '0;
      for (int i = 0; i < NUM_PADS; i++) begin
        mode_q[i] <= EVT_LEVEL;
        rcfg_q[i] <= 2'b00;
        dw1_q[i]  <= 32'h0;
      end
    end else if (wr) begin
      if (hit_dw0) begin
        tx_q[pad_idx]   <= req_wdata[TX_BIT];
        inv_q[pad_idx]  <= req_wdata[INV_BIT];
        mode_q[pad_idx] <= evt_mode_e'(req_wdata[MODE_LSB +: 2]);
        rcfg_q[pad_idx] <= req_wdata[RCFG_LSB +: 2];
      end
      if (hit_dw1) dw1_q[pad_idx] <= req_wdata;
    end
  end

  assign pad_out = tx_q;

  // ---------------- event detection ----------------
  logic [NUM_PADS-1:0] rx_sync;
  logic [NUM_PADS-1:0] pad_evt;

  for (genvar g = 0; g < NUM_PADS; g++) begin : g_pad
    gpio_pad_evt u_evt (
      .clk      (clk),
      .rst      (rst),
      .pad_i    (pad_in[g]),
      .inv_i    (inv_q[g]),
      .mode_i   (mode_q[g]),
      .rx_sync_o(rx_sync[g]),
      .evt_o    (pad_evt[g])
    );
  end

  // ---------------- status / enable ----------------
  logic [NUM_PADS-1:0] sts_q, ena_q, sts_clr;

  assign sts_clr = (wr && hit_sts) ? req_wdata[NUM_PADS-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q <= '0;
      ena_q <= '0;
    end else begin
      sts_q <= (sts_q & ~sts_clr) | pad_evt;
      if (wr && hit_ena) ena_q <= req_wdata[NUM_PADS-1:0];
    end
  end

  gpio_irq_agg #(.NUM_PADS(NUM_PADS)) u_irq (
    .clk  (clk),
    .rst  (rst),
    .sts_i(sts_q),
    .ena_i(ena_q),
    .irq_o(irq)
  );

  // ---------------- read path ----------------
  logic [31:0] rd_mux;

  always_comb begin
    rd_mux = 32'h0;
    if (hit_ptr)      rd_mux = 32'(PAD_REGION_OFS);
    else if (hit_sts) rd_mux = 32'(sts_q);
    else if (hit_ena) rd_mux = 32'(ena_q);
    else if (hit_dw0) begin
      rd_mux[TX_BIT]          = tx_q[pad_idx];
      rd_mux[RX_BIT]          = rx_sync[pad_idx];
      rd_mux[INV_BIT]         = inv_q[pad_idx];
      rd_mux[MODE_LSB +: 2]   = mode_q[pad_idx];
      rd_mux[RCFG_LSB +: 2]   = rcfg_q[pad_idx];
    end
    else if (hit_dw1) rd_mux = dw1_q[pad_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= 32'h0;
    end else begin
      rsp_valid <= req_valid & ~req_write;
      rsp_rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/gpio_pad_ctrl_chk.sv
module gpio_pad_ctrl_chk #(
  parameter int ADDR_W         = 12,
  parameter int NUM_PADS       = 32,
  parameter int PAD_REGION_OFS = 'h400,
  parameter int STS_BASE       = 'h100
) (
  input logic                clk,
  input logic                rst,
  input logic                req_valid,
  input logic                req_write,
  input logic [ADDR_W-1:0]   req_addr,
  input logic [31:0]         req_wdata,
  input logic                rsp_valid,
  input logic                irq,
  input logic [NUM_PADS-1:0] pad_out,
  input logic [NUM_PADS-1:0] sts_q,
  input logic [NUM_PADS-1:0] ena_q,
  input logic [NUM_PADS-1:0] pad_evt
);

  logic sts_wr;
  assign sts_wr = req_valid && req_write && (req_addr == ADDR_W'(STS_BASE));

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (sts_q == '0 && !irq && pad_out == '0));

  assert_read_resp_R13: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> rsp_valid);

  assert_no_write_resp_R13: assert property (@(posedge clk) disable iff (rst)
    (!req_valid || req_write) |=> !rsp_valid);

  assert_sts_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    !sts_wr |=> ((sts_q & $past(sts_q)) == $past(sts_q)));

  assert_w1c_all_R10: assert property (@(posedge clk) disable iff (rst)
    (sts_wr && req_wdata[NUM_PADS-1:0] == '1 && pad_evt == '0) |=> (sts_q == '0));

  assert_evt_sets_R6: assert property (@(posedge clk) disable iff (rst)
    (pad_evt != '0) |=> ((sts_q & $past(pad_evt)) == $past(pad_evt)));

  assert_irq_high_R12: assert property (@(posedge clk) disable iff (rst)
    (|(sts_q & ena_q)) |=> irq);

  assert_irq_low_R12: assert property (@(posedge clk) disable iff (rst)
    !(|(sts_q & ena_q)) |=> !irq);

  assert_tx_pad0_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_addr == ADDR_W'(PAD_REGION_OFS))
      |=> (pad_out[0] == $past(req_wdata[0])));

endmodule

bind gpio_pad_ctrl gpio_pad_ctrl_chk #(
  .ADDR_W        (ADDR_W),
  .NUM_PADS      (NUM_PADS),
  .PAD_REGION_OFS(PAD_REGION_OFS),
  .STS_BASE      (STS_BASE)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_write(req_write),
  .req_addr (req_addr),
  .req_wdata(req_wdata),
  .rsp_valid(rsp_valid),
  .irq      (irq),
  .pad_out  (pad_out),
  .sts_q    (sts_q),
  .ena_q    (ena_q),
  .pad_evt  (pad_evt)
);

// File: tb/gpio_pad_ctrl_test.sv
`timescale 1ns/1ps
module gpio_pad_ctrl_test;

  localparam int AW   = 12;
  localparam int NP   = 32;
  localparam int STR  = 16;
  localparam int PREG = 'h400;
  localparam int STS  = 'h100;
  localparam int ENA  = 'h120;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr  = '0;
  logic [31:0]   req_wdata = '0;
  logic          rsp_valid;
  logic [31:0]   rsp_rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out;
  logic          irq;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 1'b0;
  logic last_rsp_valid;

  always #2 clk = ~clk;

  gpio_pad_ctrl #(
    .ADDR_W(AW), .NUM_PADS(NP), .PAD_STRIDE(STR),
    .PAD_REGION_OFS(PREG), .STS_BASE(STS), .ENA_BASE(ENA)
  ) uut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(addr); req_wdata = data;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    last_rsp_valid = rsp_valid;
  endtask

  task automatic rd(input int addr, output logic [31:0] data);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(addr);
    @(negedge clk);
    req_valid = 1'b0;
    data = rsp_rdata;
    last_rsp_valid = rsp_valid;
  endtask

  function automatic int dw0(input int n); return PREG + n * STR; endfunction

  task automatic t_reset();
    logic [31:0] v;
    check("R1 irq", 32'(irq), 0);
    check("R1 pad_out", pad_out, 0);
    rd(STS, v);      check("R1 status", v, 0);
    rd(ENA, v);      check("R1 enable", v, 0);
    rd(dw0(0), v);   check("R1 pad0 dw0", v, 0);
    rd(dw0(31)+4, v); check("R1 pad31 dw1", v, 0);
  endtask

  task automatic t_pointer();
    logic [31:0] v;
    rd('h00C, v);
    check("R2 pointer", v, PREG);
    check("R13 rsp_valid on read", 32'(last_rsp_valid), 1);
    wr('h00C, 32'hFFF);
    check("R13 no rsp on write", 32'(last_rsp_valid), 0);
    rd('h00C, v);
    check("R2 pointer after write", v, PREG);
  endtask

  task automatic t_addressing();
    logic [31:0] v;
    wr(dw0(5) + 4, 32'hA5A5_1234);
    rd(dw0(5) + 4, v); check("R3 pad5 dw1", v, 32'hA5A5_1234);
    rd(dw0(4) + 4, v); check("R3 pad4 dw1 untouched", v, 0);
    rd(dw0(5) + 8, v); check("R3 slot offset 8", v, 0);
    rd('h7FC, v);      check("R3 unmapped high", v, 0);
    rd('h200, v);      check("R3 unmapped low", v, 0);
  endtask

  task automatic t_fields();
    logic [31:0] v;
    wr(dw0(3), 32'hFFFF_FFFF);
    rd(dw0(3), v);
    check("R5 dw0 fields", v, 32'hC680_0001);
    check("R4 pad_out bit3", 32'(pad_out[3]), 1);
    wr(dw0(3), 32'h0);
    wr(STS, 32'hFFFF_FFFF);
    rd(STS, v);
    check("R10 clear all", v, 0);
  endtask

  task automatic t_rx_state();
    logic [31:0] v;
    wr(dw0(7), 32'h3);
    rd(dw0(7), v);  check("R4 rx bit ignores write", v, 32'h1);
    check("R4 pad_out bit7", 32'(pad_out[7]), 1);
    pad_in[7] = 1'b1; cycles(4);
    rd(dw0(7), v);  check("R4 rx reflects input", v, 32'h3);
    rd(STS, v);     check("R6 level sets bit7", v, 32'h80);
    wr(dw0(7), 32'h0400_0001);
    wr(STS, 32'h80);
    cycles(3);
    rd(STS, v);     check("R8 mode 10 no event", v, 0);
    pad_in[7] = 1'b0;
    wr(dw0(7), 32'h0);
    cycles(3);
  endtask

  task automatic t_level();
    logic [31:0] v;
    pad_in[2] = 1'b1; cycles(4);
    rd(STS, v);      check("R6 level set", v, 32'h4);
    wr(STS, 32'h4);
    rd(STS, v);      check("R6 level re-sets while high", v, 32'h4);
    pad_in[2] = 1'b0; cycles(4);
    wr(STS, 32'h4);
    rd(STS, v);      check("R6 cleared after input low", v, 0);
  endtask

  task automatic t_rise();
    logic [31:0] v;
    wr(dw0(9), 32'h0200_0000);
    pad_in[9] = 1'b1; cycles(4);
    rd(STS, v);      check("R7 rising edge", v, 32'h200);
    wr(STS, 32'h0);
    rd(STS, v);      check("R10 zero write no effect", v, 32'h200);
    wr(STS, 32'h200);
    cycles(2);
    rd(STS, v);      check("R7 no re-set while high", v, 0);
    pad_in[9] = 1'b0; cycles(4);
    rd(STS, v);      check("R7 falling ignored", v, 0);
  endtask

  task automatic t_both();
    logic [31:0] v;
    wr(dw0(10), 32'h0600_0000);
    pad_in[10] = 1'b1; cycles(4);
    rd(STS, v);      check("R8 both rise", v, 32'h400);
    wr(STS, 32'h400);
    rd(STS, v);      check("R8 cleared", v, 0);
    pad_in[10] = 1'b0; cycles(4);
    rd(STS, v);      check("R8 both fall", v, 32'h400);
    wr(STS, 32'h400);
  endtask

  task automatic t_invert();
    logic [31:0] v;
    wr(dw0(12), 32'h0080_0000);
    cycles(2);
    rd(STS, v);      check("R9 inverted low sets", v, 32'h1000);
    pad_in[12] = 1'b1; cycles(4);
    wr(STS, 32'h1000);
    rd(STS, v);      check("R9 inverted high quiet", v, 0);
    wr(dw0(12), 32'h0480_0000);
    pad_in[12] = 1'b0; cycles(4);
    rd(STS, v);      check("R8 none mode quiet", v, 0);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    pad_in[9] = 1'b1; cycles(4);
    rd(STS, v);      check("R11 status sets while disabled", v, 32'h200);
    check("R12 irq low when disabled", 32'(irq), 0);
    wr(ENA, 32'h100);
    cycles(2);
    check("R12 irq low other enable", 32'(irq), 0);
    wr(ENA, 32'h200);
    rd(ENA, v);      check("R11 enable readback", v, 32'h200);
    check("R12 irq high", 32'(irq), 1);
    wr(STS, 32'h200);
    cycles(1);
    check("R12 irq low after ack", 32'(irq), 0);
    pad_in[9] = 1'b0;
  endtask

  initial begin
    cycles(3);
    rst = 1'b0;
    cycles(1);
    t_reset();
    t_pointer();
    t_addressing();
    t_fields();
    t_rx_state();
    t_level();
    t_rise();
    t_both();
    t_invert();
    t_irq();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule